// File: doc/BRIEF.md
# Narrow-Word Line Packer and Reader

This block decides whether an eight-word line of 32-bit words can live in half of a physical line, and stores it there. A word counts as narrow when its upper half-word only repeats bit 15. A line that qualifies keeps just the lower half of each word, in that word's fixed position. So two such lines fit in one physical line. Words that are not narrow can still ride along: each one parks its upper half in a small pool of extra half-words, and a short per-word code records where.

A parameter selects one of three packing variants:

- **All-narrow:** no pool at all.
- **Fixed pool:** one extra half-word is owned by each half.
- **Shared pool:** four extra half-words are split between the two halves, unevenly if needed.

A fill presents the line and the target half. The fit decision, the packed half-line, the per-word codes and the spilled upper halves appear combinationally, and the line is written on the clock edge while `fill_en` is high. Reads take a byte offset and a half select, and return the rebuilt 32-bit word. The physical storage is held in registers.

Top module: `nwc_line_packer`

## Requirements
- R1: A word is narrow exactly when bits 31:16 all equal bit 15. For example, 0x00007FFF and 0xFFFF8000 are narrow, and 0x00008000 is not.
- R2: With MODE all-narrow, `fill_fits` is 1 only when all eight words are narrow.
- R3: `fill_packed[16*i +: 16]` carries bits 15:0 of word i for every word i.
- R4: With MODE fixed-pool, a line fits when it has at most one wide word. That word gets code 1 in its 1-bit field `fill_xcode[i]`, and its upper half appears on `fill_spill[15:0]`. The two halves never compete for pool space.
- R5: With MODE shared-pool, a line fits only with at most three wide words. Counting in ascending word order, the k-th wide word gets code k in `fill_xcode[2*i +: 2]`, and its upper half appears on `fill_spill[16*(k-1) +: 16]`. Narrow words get code 0.
- R6: With MODE shared-pool, a line bound for one half fits only if its wide-word count plus the count used by the other half's stored narrow line is at most 4, so splits such as 1+3 are allowed. Refilling a half releases that half's own pool entries first.
- R7: A fill whose line does not fit stores all eight full words, and `line_narrow` reads 0 from the next cycle. Reads then return the full word whatever `rd_half` is.
- R8: A fill whose line fits stores it in half `fill_half`, and `line_narrow` reads 1 from the next cycle. If the physical line was already narrow, the other half's content is kept.
- R9: Reading a narrow line returns the stored 16 bits of a word with code 0, sign-extended to 32 bits.
- R10: Reading a narrow line returns, for a word with a nonzero code, its pool half-word above the stored lower 16 bits.
- R11: The word index is `rd_offset[4:2]` in both narrow and normal lines, and `rd_offset[1:0]` has no effect on `rd_data`.
- R12: After reset, `line_narrow` is 0 and every read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write the presented line on this edge |
| fill_half | input | 1 | Target half for a narrow line |
| fill_line | input | 256 | Line, word i at bits 32*i +: 32 |
| fill_fits | output | 1 | Line can be stored in half a physical line |
| fill_packed | output | 128 | Lower half-words of the line |
| fill_xcode | output | 8*CODE_W | Per-word spill codes (CODE_W is 2 in shared-pool, else 1) |
| fill_spill | output | 16*SPILL_N | Spilled upper halves in rank order (SPILL_N is 3 in shared-pool, else 1) |
| rd_offset | input | 5 | Byte offset of the word to read |
| rd_half | input | 1 | Half to read when the line is narrow |
| rd_data | output | 32 | Rebuilt 32-bit word |
| line_narrow | output | 1 | Width bit: 1 when the physical line holds narrow halves |

## Verification
The hardest state to reach is a physical line whose shared pool is fully committed across both halves, with one half then refilled. Only that case shows both that a half frees its own entries and that the other half's spilled words survive untouched.

The stimulus builds this up through fills alone:
1. A narrow line with one spilled word goes into one half.
2. A line with three wide words goes into the other half.
3. A two-wide-word line is offered, and `fill_fits` is observed to refuse it.
4. The three-wide half is refilled with different wide words.
5. Words of both halves are read back to show that each pool entry still belongs to the right owner.

// File: rtl/nwc_pkg.sv
package nwc_pkg;

   typedef enum logic [1:0] {
      PK_ALL_NARROW  = 2'd0,
      PK_FIXED_POOL  = 2'd1,
      PK_SHARED_POOL = 2'd2
   } pack_mode_e;

   // bits in each per-word spill code
   function automatic int code_w(pack_mode_e m);
      return (m == PK_SHARED_POOL) ? 2 : 1;
   endfunction

   // largest number of spilled words a single line may use
   function automatic int max_spill(pack_mode_e m);
      case (m)
         PK_SHARED_POOL: return 3;
         PK_FIXED_POOL:  return 1;
         default:        return 0;
      endcase
   endfunction

   // extra half-words per physical line (one dummy entry when unused)
   function automatic int pool_size(pack_mode_e m);
      case (m)
         PK_SHARED_POOL: return 4;
         PK_FIXED_POOL:  return 2;
         default:        return 1;
      endcase
   endfunction

   // pool entry for the spill of rank k (1-based) in a given half;
   // in shared mode half 0 grows upward and half 1 grows downward
   function automatic int pool_entry(pack_mode_e m, logic half, int rank);
      case (m)
         PK_SHARED_POOL: return half ? (4 - rank) : (rank - 1);
         PK_FIXED_POOL:  return half ? 1 : 0;
         default:        return 0;
      endcase
   endfunction

endpackage

// File: rtl/nwc_classify.sv
module nwc_classify #(
   parameter nwc_pkg::pack_mode_e MODE = nwc_pkg::PK_SHARED_POOL,
   parameter int WORDS  = 8,
   parameter int WORD_W = 32,
   localparam int HALF_W  = WORD_W / 2,
   localparam int CODE_W  = nwc_pkg::code_w(MODE),
   localparam int MAXS    = nwc_pkg::max_spill(MODE),
   localparam int SPILL_N = (MAXS > 0) ? MAXS : 1,
   localparam int POOL    = nwc_pkg::pool_size(MODE),
   localparam int CNT_W   = $clog2(WORDS + 1)
) (
   input  logic [WORDS*WORD_W-1:0]   line,
   input  logic [CNT_W-1:0]          other_used,
   output logic                      fits,
   output logic [WORDS*HALF_W-1:0]   packed_lo,
   output logic [WORDS*CODE_W-1:0]   xcode,
   output logic [SPILL_N*HALF_W-1:0] spill,
   output logic [CNT_W-1:0]          nwide
);

   logic [WORDS-1:0] is_narrow;

   // per-word narrow detection, repeated for every word position
   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      assign is_narrow[gi] =
         (line[gi*WORD_W + HALF_W +: HALF_W] == {HALF_W{line[gi*WORD_W + HALF_W - 1]}});
      assign packed_lo[gi*HALF_W +: HALF_W] = line[gi*WORD_W +: HALF_W];
   end

   // rank assignment: k-th wide word in ascending order gets code k
   always_comb begin
      int rank;
      rank  = 0;
      xcode = '0;
      spill = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (!is_narrow[i]) begin
            rank = rank + 1;
            if (rank <= MAXS) begin
               xcode[i*CODE_W +: CODE_W] = CODE_W'(rank);
               spill[(rank-1)*HALF_W +: HALF_W] = line[i*WORD_W + HALF_W +: HALF_W];
            end
         end
      end
      nwide = CNT_W'(rank);
      fits  = (rank <= MAXS) &&
              ((rank + int'(other_used) <= POOL) || (MODE != nwc_pkg::PK_SHARED_POOL));
   end

endmodule

// File: rtl/nwc_store.sv
module nwc_store #(
   parameter nwc_pkg::pack_mode_e MODE = nwc_pkg::PK_SHARED_POOL,
   parameter int WORDS  = 8,
   parameter int WORD_W = 32,
   localparam int HALF_W  = WORD_W / 2,
   localparam int CODE_W  = nwc_pkg::code_w(MODE),
   localparam int MAXS    = nwc_pkg::max_spill(MODE),
   localparam int SPILL_N = (MAXS > 0) ? MAXS : 1,
   localparam int POOL    = nwc_pkg::pool_size(MODE),
   localparam int CNT_W   = $clog2(WORDS + 1),
   localparam int IDX_W   = $clog2(WORDS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      wr_half,
   input  logic                      wr_fits,
   input  logic [WORDS*WORD_W-1:0]   wr_line,
   input  logic [WORDS*HALF_W-1:0]   wr_packed,
   input  logic [WORDS*CODE_W-1:0]   wr_xcode,
   input  logic [SPILL_N*HALF_W-1:0] wr_spill,
   input  logic [CNT_W-1:0]          wr_nwide,
   input  logic [IDX_W-1:0]          rd_word,
   input  logic                      rd_half,
   output logic [WORD_W-1:0]         rd_data,
   output logic [CNT_W-1:0]          used_lo,
   output logic [CNT_W-1:0]          used_hi,
   output logic                      narrow_q
);

   logic [WORD_W-1:0] data_q [WORDS];
   logic [CODE_W-1:0] code_q [2][WORDS];
   logic [HALF_W-1:0] pool_q [POOL];
   logic [CNT_W-1:0]  used_q [2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         narrow_q <= 1'b0;
         used_q[0] <= '0;
         used_q[1] <= '0;
         for (int i = 0; i < WORDS; i++) begin
            data_q[i]    <= '0;
            code_q[0][i] <= '0;
            code_q[1][i] <= '0;
         end
         for (int p = 0; p < POOL; p++) pool_q[p] <= '0;
      end else if (wr_en) begin
         if (wr_fits) begin
            for (int i = 0; i < WORDS; i++) begin
               if (wr_half) data_q[i][WORD_W-1:HALF_W] <= wr_packed[i*HALF_W +: HALF_W];
               else         data_q[i][HALF_W-1:0]      <= wr_packed[i*HALF_W +: HALF_W];
               code_q[wr_half][i] <= wr_xcode[i*CODE_W +: CODE_W];
            end
            for (int k = 0; k < SPILL_N; k++) begin
               if (k < int'(wr_nwide))
                  pool_q[nwc_pkg::pool_entry(MODE, wr_half, k + 1)] <= wr_spill[k*HALF_W +: HALF_W];
            end
            used_q[wr_half] <= wr_nwide;
            if (!narrow_q) used_q[~wr_half] <= '0;
            narrow_q <= 1'b1;
         end else begin
            for (int i = 0; i < WORDS; i++) begin
               data_q[i]    <= wr_line[i*WORD_W +: WORD_W];
               code_q[0][i] <= '0;
               code_q[1][i] <= '0;
            end
            used_q[0] <= '0;
            used_q[1] <= '0;
            narrow_q  <= 1'b0;
         end
      end
   end

   assign used_lo = used_q[0];
   assign used_hi = used_q[1];

   // read path: same word decode for both layouts, width bit picks slot size
   logic [WORD_W-1:0] rd_slot;
   logic [HALF_W-1:0] rd_lo;
   logic [CODE_W-1:0] rd_code;

   always_comb begin
      rd_slot = data_q[rd_word];
      rd_lo   = rd_half ? rd_slot[WORD_W-1:HALF_W] : rd_slot[HALF_W-1:0];
      rd_code = code_q[rd_half][rd_word];
      if (!narrow_q)
         rd_data = rd_slot;
      else if (rd_code == '0)
         rd_data = {{HALF_W{rd_lo[HALF_W-1]}}, rd_lo};
      else
         rd_data = {pool_q[nwc_pkg::pool_entry(MODE, rd_half, int'(rd_code))], rd_lo};
   end

   // the two halves together never claim more pool entries than exist
   assert_pool_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
      narrow_q |-> ((int'(used_q[0]) + int'(used_q[1])) <= POOL));

   // an unspilled word of a narrow line reads back sign-extended
   assert_signext_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (narrow_q && rd_code == '0) |-> (rd_data[WORD_W-1:HALF_W] == {HALF_W{rd_data[HALF_W-1]}}));

endmodule

// File: rtl/nwc_line_packer.sv
module nwc_line_packer #(
   parameter nwc_pkg::pack_mode_e MODE = nwc_pkg::PK_SHARED_POOL,
   parameter int WORDS  = 8,
   parameter int WORD_W = 32,
   localparam int HALF_W    = WORD_W / 2,
   localparam int CODE_W    = nwc_pkg::code_w(MODE),
   localparam int MAXS      = nwc_pkg::max_spill(MODE),
   localparam int SPILL_N   = (MAXS > 0) ? MAXS : 1,
   localparam int CNT_W     = $clog2(WORDS + 1),
   localparam int IDX_W     = $clog2(WORDS),
   localparam int BYTE_BITS = $clog2(WORD_W / 8),
   localparam int OFS_W     = IDX_W + BYTE_BITS
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fill_en,
   input  logic                      fill_half,
   input  logic [WORDS*WORD_W-1:0]   fill_line,
   output logic                      fill_fits,
   output logic [WORDS*HALF_W-1:0]   fill_packed,
   output logic [WORDS*CODE_W-1:0]   fill_xcode,
   output logic [SPILL_N*HALF_W-1:0] fill_spill,
   input  logic [OFS_W-1:0]          rd_offset,
   input  logic                      rd_half,
   output logic [WORD_W-1:0]         rd_data,
   output logic                      line_narrow
);

   initial begin
      assert (WORDS >= 2 && (WORDS & (WORDS - 1)) == 0)
         else $error("WORDS must be a power of two, at least 2");
      assert (WORD_W >= 16 && (WORD_W % 16) == 0)
         else $error("WORD_W must be a multiple of 16");
   end

   logic [CNT_W-1:0] used_lo, used_hi, other_used, nwide;
   logic             unused_byte_sel;

   assign other_used      = fill_half ? used_lo : used_hi;
   assign unused_byte_sel = ^rd_offset[BYTE_BITS-1:0];

   nwc_classify #(.MODE(MODE), .WORDS(WORDS), .WORD_W(WORD_W)) u_classify (
      .line       (fill_line),
      .other_used (other_used),
      .fits       (fill_fits),
      .packed_lo  (fill_packed),
      .xcode      (fill_xcode),
      .spill      (fill_spill),
      .nwide      (nwide)
   );

   nwc_store #(.MODE(MODE), .WORDS(WORDS), .WORD_W(WORD_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (fill_en),
      .wr_half   (fill_half),
      .wr_fits   (fill_fits),
      .wr_line   (fill_line),
      .wr_packed (fill_packed),
      .wr_xcode  (fill_xcode),
      .wr_spill  (fill_spill),
      .wr_nwide  (nwide),
      .rd_word   (rd_offset[OFS_W-1:BYTE_BITS]),
      .rd_half   (rd_half),
      .rd_data   (rd_data),
      .used_lo   (used_lo),
      .used_hi   (used_hi),
      .narrow_q  (line_narrow)
   );

   assert_fit_sets_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && fill_fits) |=> line_narrow);

   assert_wide_clears_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !fill_fits) |=> !line_narrow);

   assert_width_holds_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_en |=> $stable(line_narrow));

endmodule

// File: tb/tb_nwc_line_packer.sv
module tb_nwc_line_packer;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fill_en = 1'b0;
   logic         fill_half = 1'b0;
   logic [255:0] fill_line = '0;
   logic [4:0]   rd_offset = '0;
   logic         rd_half = 1'b0;

   logic         fits2, fits1, fits0;
   logic [127:0] packed2, packed1, packed0;
   logic [15:0]  xcode2;
   logic [7:0]   xcode1, xcode0;
   logic [47:0]  spill2;
   logic [15:0]  spill1, spill0;
   logic [31:0]  rdata2, rdata1, rdata0;
   logic         narrow2, narrow1, narrow0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   nwc_line_packer #(.MODE(nwc_pkg::PK_SHARED_POOL)) dut (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_half(fill_half),
      .fill_line(fill_line), .fill_fits(fits2), .fill_packed(packed2),
      .fill_xcode(xcode2), .fill_spill(spill2), .rd_offset(rd_offset),
      .rd_half(rd_half), .rd_data(rdata2), .line_narrow(narrow2));

   nwc_line_packer #(.MODE(nwc_pkg::PK_FIXED_POOL)) dut_fixed (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_half(fill_half),
      .fill_line(fill_line), .fill_fits(fits1), .fill_packed(packed1),
      .fill_xcode(xcode1), .fill_spill(spill1), .rd_offset(rd_offset),
      .rd_half(rd_half), .rd_data(rdata1), .line_narrow(narrow1));

   nwc_line_packer #(.MODE(nwc_pkg::PK_ALL_NARROW)) dut_awn (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_half(fill_half),
      .fill_line(fill_line), .fill_fits(fits0), .fill_packed(packed0),
      .fill_xcode(xcode0), .fill_spill(spill0), .rd_offset(rd_offset),
      .rd_half(rd_half), .rd_data(rdata0), .line_narrow(narrow0));

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [255:0] mk(input logic [31:0] a0, a1, a2, a3, a4, a5, a6, a7);
      return {a7, a6, a5, a4, a3, a2, a1, a0};
   endfunction

   function automatic logic [127:0] lower_halves(input logic [255:0] l);
      logic [127:0] r;
      for (int i = 0; i < 8; i++) r[i*16 +: 16] = l[i*32 +: 16];
      return r;
   endfunction

   // present a line without writing it; outputs settle before the next edge
   task automatic present(input logic half, input logic [255:0] l);
      @(negedge clk);
      fill_en = 1'b0; fill_half = half; fill_line = l;
      #1;
   endtask

   task automatic commit(input logic half, input logic [255:0] l);
      @(negedge clk);
      fill_en = 1'b1; fill_half = half; fill_line = l;
      @(negedge clk);
      fill_en = 1'b0;
      #1;
   endtask

   task automatic rd(input logic half, input logic [4:0] ofs);
      rd_half = half; rd_offset = ofs;
      #1;
   endtask

   task automatic t_reset;
      rd(1'b0, 5'd0);
      chk("R12 width bit after reset", 128'(narrow2), 128'd0);
      rd(1'b1, 5'd12);
      chk("R12 read after reset", 128'(rdata2), 128'd0);
   endtask

   task automatic t_single_wide;
      logic [255:0] l;
      l = mk(32'h00007FFF, 32'hFFFF8000, 32'h00008000, 0, 0, 0, 0, 32'hFFFFFFFF);
      present(1'b0, l);
      chk("R1/R2 one wide word refused by all-narrow", 128'(fits0), 128'd0);
      chk("R4 fixed pool accepts one wide", 128'(fits1), 128'd1);
      chk("R4 fixed pool code", 128'(xcode1), 128'h04);
      chk("R4 fixed pool spill", 128'(spill1), 128'h0000);
      chk("R5 shared pool code rank 1", 128'(xcode2), 128'h0010);
      commit(1'b0, l);
      chk("R8 narrow after fitting fill", 128'(narrow2), 128'd1);
      chk("R7 all-narrow mode stored normal", 128'(narrow0), 128'd0);
      rd(1'b0, 5'd8);
      chk("R10 spilled word rebuilt", 128'(rdata2), 128'h00008000);
      chk("R10 fixed pool spilled word", 128'(rdata1), 128'h00008000);
      rd(1'b1, 5'd8);
      chk("R7 normal line ignores half", 128'(rdata0), 128'h00008000);
      rd(1'b0, 5'd0);
      chk("R9 positive narrow", 128'(rdata2), 128'h00007FFF);
      rd(1'b0, 5'd4);
      chk("R9 negative narrow", 128'(rdata2), 128'hFFFF8000);
   endtask

   task automatic t_all_narrow;
      logic [255:0] l;
      l = mk(32'h00001234, 32'hFFFFABCD, 32'h00000055, 32'hFFFF8001,
             0, 32'h00007000, 32'hFFFFFFFE, 32'h00000001);
      present(1'b0, l);
      chk("R2 all narrow fits", 128'(fits0), 128'd1);
      chk("R3 packed lower halves", packed2, lower_halves(l));
      commit(1'b0, l);
      rd(1'b0, 5'd4);
      chk("R9 read sign-extended", 128'(rdata2), 128'hFFFFABCD);
      rd(1'b0, 5'd7);
      chk("R11 byte bits ignored", 128'(rdata2), 128'hFFFFABCD);
      rd(1'b0, 5'd27);
      chk("R11 word 6 by offset", 128'(rdata2), 128'hFFFFFFFE);
   endtask

   task automatic t_three_wide;
      logic [255:0] l;
      l = mk(32'h00000010, 32'h12345678, 32'hFFFFFF00, 0,
             32'hABCD0001, 0, 32'h7FFF0000, 0);
      present(1'b1, l);
      chk("R5 three wide fit", 128'(fits2), 128'd1);
      chk("R5 rank codes", 128'(xcode2), 128'h3204);
      chk("R5 spill order", 128'(spill2), 128'h7FFFABCD1234);
      chk("R3 packed with wide words", packed2, lower_halves(l));
      commit(1'b1, l);
      rd(1'b1, 5'd16);
      chk("R10 half1 rank2", 128'(rdata2), 128'hABCD0001);
      rd(1'b1, 5'd25);
      chk("R10 half1 rank3", 128'(rdata2), 128'h7FFF0000);
      rd(1'b1, 5'd4);
      chk("R10 half1 rank1", 128'(rdata2), 128'h12345678);
      rd(1'b0, 5'd4);
      chk("R8 other half kept", 128'(rdata2), 128'hFFFFABCD);
   endtask

   task automatic t_pool_share;
      logic [255:0] l;
      present(1'b0, mk(32'h55550000, 32'h66660000, 0, 0, 0, 0, 0, 0));
      chk("R6 2+3 exceeds pool", 128'(fits2), 128'd0);
      l = mk(32'hCAFE0003, 0, 0, 32'hFFFFFFF0, 0, 0, 0, 0);
      present(1'b0, l);
      chk("R6 1+3 fits", 128'(fits2), 128'd1);
      commit(1'b0, l);
      rd(1'b0, 5'd0);
      chk("R6 half0 spill", 128'(rdata2), 128'hCAFE0003);
      rd(1'b0, 5'd12);
      chk("R9 half0 narrow", 128'(rdata2), 128'hFFFFFFF0);
      rd(1'b1, 5'd24);
      chk("R6 half1 rank3 intact", 128'(rdata2), 128'h7FFF0000);
      rd(1'b1, 5'd4);
      chk("R6 half1 rank1 intact", 128'(rdata2), 128'h12345678);
      l = mk(32'h11110000, 0, 32'h22220000, 0, 0, 32'h33330000, 0, 0);
      present(1'b1, l);
      chk("R6 refill releases own entries", 128'(fits2), 128'd1);
      commit(1'b1, l);
      rd(1'b1, 5'd20);
      chk("R10 refilled rank3", 128'(rdata2), 128'h33330000);
      rd(1'b1, 5'd0);
      chk("R10 refilled rank1", 128'(rdata2), 128'h11110000);
      rd(1'b0, 5'd0);
      chk("R6 half0 survives refill", 128'(rdata2), 128'hCAFE0003);
   endtask

   task automatic t_normal_line;
      logic [255:0] l;
      l = mk(32'h10000000, 32'h20000000, 32'h30000000, 32'h40000000,
             0, 0, 0, 32'h00000009);
      present(1'b0, l);
      chk("R5 four wide refused", 128'(fits2), 128'd0);
      commit(1'b0, l);
      chk("R7 width bit cleared", 128'(narrow2), 128'd0);
      rd(1'b1, 5'd8);
      chk("R7 full word half1", 128'(rdata2), 128'h30000000);
      rd(1'b0, 5'd10);
      chk("R11 full word offset bits", 128'(rdata2), 128'h30000000);
   endtask

   task automatic t_fixed_limit;
      present(1'b1, mk(0, 32'h01230000, 0, 0, 0, 0, 32'h45670000, 0));
      chk("R4 fixed pool refuses two wide", 128'(fits1), 128'd0);
      chk("R5 shared pool takes two wide", 128'(fits2), 128'd1);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog R12 actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_single_wide();
      t_all_narrow();
      t_three_wide();
      t_pool_share();
      t_normal_line();
      t_fixed_limit();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule